// File: doc/BRIEF.md
# Double-Buffered Serial DAC Receive Logic

This block is the digital receive side of a 10-bit voltage-output DAC. A host writes 16-bit command words over a three-wire serial port made of an active-low select, a serial clock and a data line. The block keeps two registers, a staging (input) register and the register that drives the converter. It also holds a power-down flag that tells the analog stage to float its output and reference.

The serial pins are sampled by a faster system clock through a synchronizer. Rising serial-clock edges are then detected in the system domain. A word is acted on only when select rises after exactly sixteen serial clocks. At that moment the 3-bit command field picks one action: stage data, write the converter directly, do both, move the staged value to the converter, or power down.

Top module: `sdac_rx`

## Requirements
- R1: After reset, `dac_code` is 0, `shdn` is 0, and the staging register holds 0. A transfer command issued right after reset therefore yields `dac_code` = 0.
- R2: A word is 16 bits, most significant bit first. Bits 15..13 are the command, bits 12..3 are the 10-bit data (bit 12 is data MSB), and bits 2..0 are filler bits that have no effect.
- R3: A bit is taken on each rising serial-clock edge while select is low. While select is high, serial-clock and data activity changes nothing, and the next word is received correctly.
- R4: The outputs change only after a rising edge of select. They stay unchanged while the bits of a word are being shifted in.
- R5: Command 001 loads the data into the staging register and leaves `dac_code` and `shdn` unchanged.
- R6: Command 010 loads the data into the converter register, clears `shdn` and leaves the staging register unchanged.
- R7: Command 011 loads the data into both registers and clears `shdn`.
- R8: Command 100 copies the staging register into the converter register and clears `shdn`. Its data bits are ignored.
- R9: Command 101 sets `shdn` and keeps both registers. Its data bits are ignored.
- R10: Commands 000, 110 and 111 change nothing.
- R11: If select rises after any count of serial clocks other than 16 (for example 15 or 17), the word is dropped and no register changes.
- R12: A word sent as two 8-bit bursts with an idle gap, inside one select-low period, is accepted like a continuous word.
- R13: While `shdn` is set, words are still received. Command 001 updates the staging register and `shdn` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low serial select; a rising edge commits the word |
| sclk | input | 1 | Serial clock, idle low, data taken on its rising edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | DATA_W | Converter register value |
| shdn | output | 1 | Power-down flag; high asks the analog stage to go high-impedance |

## Verification
The bench sweeps all eight command codes across ten data patterns: all zeros, all ones, two alternating-bit patterns and arithmetic patterns. A scrambled field order, or data taken from the wrong bit positions, then shows up as a wrong code. Because the sweep runs repeatedly through staging, direct, combined, transfer and power-down commands, it tells apart writes that hit the wrong register and wrong power-down entry or exit. Power-down is entered both before staging loads and before transfers. Words of 15 and 17 clocks, split bursts, and clock toggling with select high check the framing. Those cases tell a correct bit count from an off-by-one count or a counter that wraps.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int CMD_W = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP     = 3'b000,
      CMD_STAGE   = 3'b001,
      CMD_DIRECT  = 3'b010,
      CMD_BOTH    = 3'b011,
      CMD_XFER    = 3'b100,
      CMD_SLEEP   = 3'b101,
      CMD_RSV6    = 3'b110,
      CMD_RSV7    = 3'b111
   } sdac_cmd_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int             N      = 3,
   parameter int             STAGES = 2,
   parameter logic [N-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         // inputs already in the clk domain
         assign q = d;
      end else begin : g_chain
         logic [N-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int PAY_W   = 13,
   parameter int FRAME_W = 16,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s,
   input  logic             sclk_s,
   input  logic             din_s,
   output logic [PAY_W-1:0] payload,
   output logic [CNT_W-1:0] bit_cnt,
   output logic             frame_done
);
   localparam logic [CNT_W-1:0] PAY_N  = CNT_W'(PAY_W);
   localparam logic [CNT_W-1:0] FULL_N = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] SAT_N  = CNT_W'(FRAME_W + 1);

   logic sclk_d, cs_d;
   logic sclk_rise, cs_rise;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign cs_rise   = cs_s & ~cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         cs_d    <= 1'b1;
         bit_cnt <= '0;
         payload <= '0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
         if (cs_s) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            // only the command and data bits are stored; filler bits are counted
            if (bit_cnt < PAY_N) payload <= {payload[PAY_W-2:0], din_s};
            if (bit_cnt != SAT_N) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   assign frame_done = cs_rise & (bit_cnt == FULL_N);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
   import sdac_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] in_q,
   output logic [DATA_W-1:0] dac_q,
   output logic              shdn_q
);
   sdac_cmd_e op;
   assign op = sdac_cmd_e'(cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= '0;
         dac_q  <= '0;
         shdn_q <= 1'b0;
      end else if (commit) begin
         case (op)
            CMD_STAGE:  in_q <= data;
            CMD_DIRECT: begin
               dac_q  <= data;
               shdn_q <= 1'b0;
            end
            CMD_BOTH: begin
               in_q   <= data;
               dac_q  <= data;
               shdn_q <= 1'b0;
            end
            CMD_XFER: begin
               dac_q  <= in_q;
               shdn_q <= 1'b0;
            end
            CMD_SLEEP:  shdn_q <= 1'b1;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
   import sdac_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int SUB_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdin,
   output logic [DATA_W-1:0] dac_code,
   output logic              shdn
);
   localparam int PAY_W   = CMD_W + DATA_W;
   localparam int FRAME_W = PAY_W + SUB_W;
   localparam int CNT_W   = $clog2(FRAME_W + 2);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("sdac_rx: DATA_W must be at least 1");
      end
      if (SUB_W < 0) begin : g_bad_sub
         $error("sdac_rx: SUB_W must not be negative");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("sdac_rx: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic [PAY_W-1:0]  payload;
   logic [CNT_W-1:0]  bit_cnt;
   logic              commit_go;
   logic [CMD_W-1:0]  frm_cmd;
   logic [DATA_W-1:0] frm_data;
   logic [DATA_W-1:0] in_q;

   sdac_sync #(
      .N      (3),
      .STAGES (SYNC_STAGES),
      .RST    (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sclk, sdin}),
      .q     (pins_s)
   );

   sdac_shifter #(
      .PAY_W   (PAY_W),
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (pins_s[2]),
      .sclk_s     (pins_s[1]),
      .din_s      (pins_s[0]),
      .payload    (payload),
      .bit_cnt    (bit_cnt),
      .frame_done (commit_go)
   );

   assign frm_cmd  = payload[PAY_W-1 -: CMD_W];
   assign frm_data = payload[DATA_W-1:0];

   sdac_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit_go),
      .cmd    (frm_cmd),
      .data   (frm_data),
      .in_q   (in_q),
      .dac_q  (dac_code),
      .shdn_q (shdn)
   );
endmodule

// File: rtl/sdac_rx_chk.sv
module sdac_rx_chk
   import sdac_pkg::*;
#(
   parameter int DATA_W  = 10,
   parameter int FRAME_W = 16,
   parameter int CNT_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              commit,
   input logic [CMD_W-1:0]  cmd,
   input logic [DATA_W-1:0] data,
   input logic [DATA_W-1:0] in_reg,
   input logic [DATA_W-1:0] dac_code,
   input logic              shdn,
   input logic [CNT_W-1:0]  bit_cnt
);
   AST_DAC_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(dac_code)); // R4
   AST_SHDN_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(shdn)); // R4
   AST_STAGE_KEEPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cmd == CMD_STAGE) |=> ($stable(dac_code) && $stable(shdn) && in_reg == $past(data))); // R5
   AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cmd == CMD_DIRECT) |=> (dac_code == $past(data) && !shdn && $stable(in_reg))); // R6
   AST_BOTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cmd == CMD_BOTH) |=> (dac_code == $past(data) && in_reg == $past(data) && !shdn)); // R7
   AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cmd == CMD_XFER) |=> (dac_code == $past(in_reg) && !shdn)); // R8
   AST_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cmd == CMD_SLEEP) |=> (shdn && $stable(dac_code) && $stable(in_reg))); // R9
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1)); // R11
endmodule

bind sdac_rx sdac_rx_chk #(
   .DATA_W  (DATA_W),
   .FRAME_W (FRAME_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .commit   (commit_go),
   .cmd      (frm_cmd),
   .data     (frm_data),
   .in_reg   (in_q),
   .dac_code (dac_code),
   .shdn     (shdn),
   .bit_cnt  (bit_cnt)
);

// File: tb/sdac_rx_bench.sv
module sdac_rx_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdin = 1'b0;
   logic [9:0] dac_code;
   logic shdn;

   always #5 clk = ~clk;

   sdac_rx u_sdac_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdin     (sdin),
      .dac_code (dac_code),
      .shdn     (shdn)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [9:0] m_in = '0;
   logic [9:0] m_dac = '0;
   logic m_shdn = 1'b0;

   task automatic check(string req);
      n_vec++;
      if (dac_code !== m_dac || shdn !== m_shdn) begin
         n_bad++;
         $display("FAIL %s: dac_code=%h shdn=%b, expected dac_code=%h shdn=%b",
                  req, dac_code, shdn, m_dac, m_shdn);
      end
   endtask

   task automatic half();
      repeat (5) @(negedge clk);
   endtask

   function automatic string req_of(logic [2:0] c, logic sd);
      case (c)
         3'b001:  return sd ? "R13" : "R5";
         3'b010:  return "R6 R2";
         3'b011:  return "R7";
         3'b100:  return "R8";
         3'b101:  return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic void apply(logic [2:0] c, logic [9:0] d);
      case (c)
         3'b001: m_in = d;
         3'b010: begin m_dac = d; m_shdn = 1'b0; end
         3'b011: begin m_in = d; m_dac = d; m_shdn = 1'b0; end
         3'b100: begin m_dac = m_in; m_shdn = 1'b0; end
         3'b101: m_shdn = 1'b1;
         default: ;
      endcase
   endfunction

   task automatic send(logic [2:0] c, logic [9:0] d, int nbits, bit split, string req);
      logic [15:0] w;
      w = {c, d, 3'b000};
      cs_n = 1'b0;
      half();
      for (int i = 0; i < nbits; i++) begin
         sdin = (i < 16) ? w[15-i] : 1'b0;
         half();
         sclk = 1'b1;
         half();
         sclk = 1'b0;
         if (split && i == 7) repeat (30) @(negedge clk);
      end
      half();
      check("R4");
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      if (nbits == 16) apply(c, d);
      check(req);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1");
      // transfer right after reset exposes the staging reset value
      send(3'b100, 10'h3FF, 16, 1'b0, "R1");

      // sweep every command over several data patterns
      for (int k = 0; k < 10; k++) begin
         logic [9:0] pat;
         case (k)
            0: pat = 10'h000;
            1: pat = 10'h3FF;
            2: pat = 10'h155;
            3: pat = 10'h2AA;
            default: pat = 10'((k * 97 + 13) & 10'h3FF);
         endcase
         for (int c = 0; c < 8; c++) begin
            logic [9:0] d;
            d = 10'((pat + c * 37) & 10'h3FF);
            send(3'(c), d, 16, 1'b0, req_of(3'(c), m_shdn));
         end
      end

      // power down then leave it by transfer
      send(3'b001, 10'h0F0, 16, 1'b0, "R5");
      send(3'b101, 10'h3FF, 16, 1'b0, "R9");
      send(3'b001, 10'h10F, 16, 1'b0, "R13");
      send(3'b100, 10'h000, 16, 1'b0, "R8");
      send(3'b101, 10'h000, 16, 1'b0, "R9");
      send(3'b011, 10'h2C3, 16, 1'b0, "R7");

      // wrong bit counts are dropped
      send(3'b010, 10'h05A, 15, 1'b0, "R11");
      send(3'b011, 10'h1A5, 17, 1'b0, "R11");
      send(3'b101, 10'h000, 15, 1'b0, "R11");
      send(3'b100, 10'h000, 20, 1'b0, "R11");

      // two bursts within one select-low period
      send(3'b010, 10'h36C, 16, 1'b1, "R12");
      send(3'b011, 10'h0C9, 16, 1'b1, "R12");

      // activity with select high must do nothing
      for (int i = 0; i < 20; i++) begin
         sdin = i[0];
         half();
         sclk = 1'b1;
         half();
         sclk = 1'b0;
      end
      repeat (8) @(negedge clk);
      check("R3");
      send(3'b010, 10'h2E7, 16, 1'b0, "R3");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule